// File: doc/BRIEF.md
# Hypercube Message Routing Node

This block is the router at one vertex of a binary n-cube network. The dimension count `DIMS` sets the size of the network: it holds 2^DIMS nodes, and each node has one bidirectional link per dimension. The neighbour on link `d` has an address that differs from this node's address in bit `d` only. The node takes messages from its local processor port and from each of its incoming links. A message is a destination address, a hop counter and a payload word. For each message the node either hands it to the local output or sends it on exactly one outgoing link.

The routing decision works on the XOR of the destination and the node's own address (`NODE_ID`). A zero result means the message has arrived, so it goes to the local output. Otherwise it leaves on the link named by the lowest set bit of the XOR. This dimension order makes every hop predictable, so a message makes exactly as many link traversals as the XOR has set bits. Each output has a single register stage. A message that crosses a link has its hop counter incremented, which lets a receiver confirm the length of the path. All ports use valid/ready handshakes.

Top module: `hcube_node`

## Requirements
- R1: While reset is asserted and right after it is released, every output valid (local and all links) is low.
- R2: A message whose destination equals `NODE_ID` is presented on the local output with its destination, hop count and payload unchanged.
- R3: A message whose destination differs from `NODE_ID` is presented on link output `d` only, where `d` is the lowest bit index set in destination XOR `NODE_ID`. Link `d` occupies bit `d` of the link vectors and bits `d*W +: W` of each flattened field.
- R4: A message sent out on a link carries its incoming hop count plus one. Across a network of these nodes, a message injected with hop count 0 arrives with hop count equal to the number of set bits in source XOR destination.
- R5: A message accepted at a clock edge is valid on its output from that edge onward, a latency of one cycle.
- R6: When several inputs want the same free output in one cycle, link input 0 wins over link 1, which wins over higher links, and the local input wins last. Every input that loses sees its ready low.
- R7: An output that is valid and not taken keeps its valid and fields stable. While an output is occupied, no input that targets it sees ready high.
- R8: The payload word reaches its output unchanged.
- R9: In a full n-cube of these nodes, every source-destination pair, including a node sending to itself, is delivered exactly once at the destination's local output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_in_valid | input | 1 | Local processor offers a message |
| loc_in_ready | output | 1 | Local message accepted this cycle |
| loc_in_dest | input | DIMS | Destination node address |
| loc_in_hops | input | HOP_W | Hop counter of the offered message |
| loc_in_data | input | DATA_W | Payload word |
| loc_out_valid | output | 1 | Delivered message present |
| loc_out_ready | input | 1 | Local processor takes the delivered message |
| loc_out_dest | output | DIMS | Destination of the delivered message |
| loc_out_hops | output | HOP_W | Links crossed by the delivered message |
| loc_out_data | output | DATA_W | Delivered payload |
| lnk_in_valid | input | DIMS | Per-link incoming valid |
| lnk_in_ready | output | DIMS | Per-link incoming ready |
| lnk_in_dest | input | DIMS*DIMS | Incoming destinations, flattened per link |
| lnk_in_hops | input | DIMS*HOP_W | Incoming hop counts, flattened per link |
| lnk_in_data | input | DIMS*DATA_W | Incoming payloads, flattened per link |
| lnk_out_valid | output | DIMS | Per-link outgoing valid |
| lnk_out_ready | input | DIMS | Per-link outgoing ready |
| lnk_out_dest | output | DIMS*DIMS | Outgoing destinations, flattened per link |
| lnk_out_hops | output | DIMS*HOP_W | Outgoing hop counts, flattened per link |
| lnk_out_data | output | DIMS*DATA_W | Outgoing payloads, flattened per link |

## Verification
The assertions rely on the hop counter of each incoming message being at least one below its maximum value, so that adding one never wraps to zero. The stimulus meets this by injecting hop counts of 0, 1 or 2 and by never letting a path exceed DIMS links. They also rely on each sender holding its fields steady while valid waits for ready. Every bench task keeps an input's valid and fields unchanged until it has seen ready high before a clock edge. The checks on ready cover both the fixed priority order and the rule that a full output blocks its inputs. The network test then repeats delivery for all 64 pairs of an eight-node cube.

// File: rtl/hcube_node.sv
module hcube_node #(
  parameter int DIMS = 3,
  parameter int DATA_W = 16,
  parameter int HOP_W = $clog2(DIMS + 1),
  parameter logic [DIMS-1:0] NODE_ID = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     loc_in_valid,
  output logic                     loc_in_ready,
  input  logic [DIMS-1:0]          loc_in_dest,
  input  logic [HOP_W-1:0]         loc_in_hops,
  input  logic [DATA_W-1:0]        loc_in_data,
  output logic                     loc_out_valid,
  input  logic                     loc_out_ready,
  output logic [DIMS-1:0]          loc_out_dest,
  output logic [HOP_W-1:0]         loc_out_hops,
  output logic [DATA_W-1:0]        loc_out_data,
  input  logic [DIMS-1:0]          lnk_in_valid,
  output logic [DIMS-1:0]          lnk_in_ready,
  input  logic [DIMS*DIMS-1:0]     lnk_in_dest,
  input  logic [DIMS*HOP_W-1:0]    lnk_in_hops,
  input  logic [DIMS*DATA_W-1:0]   lnk_in_data,
  output logic [DIMS-1:0]          lnk_out_valid,
  input  logic [DIMS-1:0]          lnk_out_ready,
  output logic [DIMS*DIMS-1:0]     lnk_out_dest,
  output logic [DIMS*HOP_W-1:0]    lnk_out_hops,
  output logic [DIMS*DATA_W-1:0]   lnk_out_data
);
  localparam int PORTS = DIMS + 1;
  localparam int LOC = DIMS;

  logic [PORTS-1:0]  iv, ordy, ov, gnt;
  logic [DIMS-1:0]   idest [PORTS];
  logic [HOP_W-1:0]  ihops [PORTS];
  logic [DATA_W-1:0] idata [PORTS];
  logic [DIMS-1:0]   odest [PORTS];
  logic [HOP_W-1:0]  ohops [PORTS];
  logic [DATA_W-1:0] odata [PORTS];
  logic [PORTS-1:0]  req   [PORTS];
  logic [PORTS-1:0]  want  [PORTS];
  logic [PORTS-1:0]  win   [PORTS];

  assign iv            = {loc_in_valid, lnk_in_valid};
  assign ordy          = {loc_out_ready, lnk_out_ready};
  assign loc_in_ready  = gnt[LOC];
  assign lnk_in_ready  = gnt[DIMS-1:0];
  assign loc_out_valid = ov[LOC];
  assign lnk_out_valid = ov[DIMS-1:0];
  assign loc_out_dest  = odest[LOC];
  assign loc_out_hops  = ohops[LOC];
  assign loc_out_data  = odata[LOC];
  assign idest[LOC]    = loc_in_dest;
  assign ihops[LOC]    = loc_in_hops;
  assign idata[LOC]    = loc_in_data;

  for (genvar d = 0; d < DIMS; d++) begin : g_link
    assign idest[d] = lnk_in_dest[d*DIMS +: DIMS];
    assign ihops[d] = lnk_in_hops[d*HOP_W +: HOP_W];
    assign idata[d] = lnk_in_data[d*DATA_W +: DATA_W];
    assign lnk_out_dest[d*DIMS +: DIMS]    = odest[d];
    assign lnk_out_hops[d*HOP_W +: HOP_W]  = ohops[d];
    assign lnk_out_data[d*DATA_W +: DATA_W] = odata[d];
  end

  // Route: all-zero difference goes local, else the lowest differing axis.
  for (genvar i = 0; i < PORTS; i++) begin : g_route
    logic [DIMS-1:0] diff;
    assign diff   = idest[i] ^ NODE_ID;
    assign req[i] = (diff == '0) ? (PORTS'(1) << LOC)
                                 : {1'b0, diff & (~diff + DIMS'(1))};
  end

  // Lowest input index wins each output; only an empty output accepts.
  always_comb begin
    gnt = '0;
    for (int o = 0; o < PORTS; o++) begin
      want[o] = '0;
      for (int i = 0; i < PORTS; i++) want[o][i] = iv[i] & req[i][o];
      win[o] = want[o] & (~want[o] + PORTS'(1));
      if (!ov[o]) gnt = gnt | win[o];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov <= '0;
    else
      for (int o = 0; o < PORTS; o++) begin
        if (ov[o]) begin
          if (ordy[o]) ov[o] <= 1'b0;
        end else if (|want[o]) ov[o] <= 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < PORTS; o++)
      if (!ov[o])
        for (int i = 0; i < PORTS; i++)
          if (win[o][i]) begin
            odest[o] <= idest[i];
            ohops[o] <= (o == LOC) ? ihops[i] : ihops[i] + HOP_W'(1);
            odata[o] <= idata[i];
          end
  end

  for (genvar o = 0; o < PORTS; o++) begin : g_chk
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ov[o] && !ordy[o]) |=> (ov[o] && $stable(odata[o]) && $stable(odest[o]) && $stable(ohops[o])));
    p_single_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt & want[o]));
    if (o < DIMS) begin : g_lnk
      localparam logic [DIMS-1:0] LOWM = DIMS'((64'd1 << (o + 1)) - 64'd1);
      localparam logic [DIMS-1:0] AXIS = DIMS'(64'd1 << o);
      p_lowest_axis_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ov[o] |-> (((odest[o] ^ NODE_ID) & LOWM) == AXIS));
      p_hop_counted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ov[o] |-> (ohops[o] != '0));
    end else begin : g_loc
      p_local_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ov[o] |-> (odest[o] == NODE_ID));
    end
  end

  p_local_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_in_valid && loc_in_ready && loc_in_dest == NODE_ID) |=> loc_out_valid);

endmodule

// File: tb/hcube_node_bench.sv
module hcube_node_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIMS = 3;
  localparam int DW = 16;
  localparam int HW = 2;
  localparam int N = 1 << DIMS;
  localparam logic [DIMS-1:0] ME = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int low_axis(input int x);
    for (int k = 0; k < DIMS; k++) if (x[k]) return k;
    return DIMS;
  endfunction

  // ---------------- standalone node ----------------
  logic s_ci_v = 0, s_co_rdy = 1;
  logic [DIMS-1:0] s_ci_dest = '0;
  logic [HW-1:0] s_ci_hops = '0;
  logic [DW-1:0] s_ci_data = '0;
  logic [DIMS-1:0] s_li_v = '0, s_lo_rdy = '1;
  logic [DIMS*DIMS-1:0] s_li_dest = '0;
  logic [DIMS*HW-1:0] s_li_hops = '0;
  logic [DIMS*DW-1:0] s_li_data = '0;
  logic s_ci_rdy, s_co_v;
  logic [DIMS-1:0] s_co_dest;
  logic [HW-1:0] s_co_hops;
  logic [DW-1:0] s_co_data;
  logic [DIMS-1:0] s_li_rdy, s_lo_v;
  logic [DIMS*DIMS-1:0] s_lo_dest;
  logic [DIMS*HW-1:0] s_lo_hops;
  logic [DIMS*DW-1:0] s_lo_data;

  hcube_node #(.DIMS(DIMS), .DATA_W(DW), .HOP_W(HW), .NODE_ID(ME)) u_hcube_node (
    .clk(clk), .rst_n(rst_n),
    .loc_in_valid(s_ci_v), .loc_in_ready(s_ci_rdy), .loc_in_dest(s_ci_dest),
    .loc_in_hops(s_ci_hops), .loc_in_data(s_ci_data),
    .loc_out_valid(s_co_v), .loc_out_ready(s_co_rdy), .loc_out_dest(s_co_dest),
    .loc_out_hops(s_co_hops), .loc_out_data(s_co_data),
    .lnk_in_valid(s_li_v), .lnk_in_ready(s_li_rdy), .lnk_in_dest(s_li_dest),
    .lnk_in_hops(s_li_hops), .lnk_in_data(s_li_data),
    .lnk_out_valid(s_lo_v), .lnk_out_ready(s_lo_rdy), .lnk_out_dest(s_lo_dest),
    .lnk_out_hops(s_lo_hops), .lnk_out_data(s_lo_data));

  // ---------------- full cube ----------------
  logic [N-1:0] c_ci_v = '0;
  logic [DIMS-1:0] c_ci_dest [N];
  logic [DW-1:0] c_ci_data [N];
  wire [N-1:0] c_ci_rdy, c_co_v;
  wire [DIMS-1:0] c_co_dest [N];
  wire [HW-1:0] c_co_hops [N];
  wire [DW-1:0] c_co_data [N];
  wire [DIMS-1:0] lo_v [N];
  wire [DIMS-1:0] li_rdy [N];
  wire [DIMS*DIMS-1:0] lo_dest [N];
  wire [DIMS*HW-1:0] lo_hops [N];
  wire [DIMS*DW-1:0] lo_data [N];
  wire [DIMS-1:0] li_v [N];
  wire [DIMS-1:0] lo_rdy [N];
  wire [DIMS*DIMS-1:0] li_dest [N];
  wire [DIMS*HW-1:0] li_hops [N];
  wire [DIMS*DW-1:0] li_data [N];

  for (genvar i = 0; i < N; i++) begin : g_cube
    for (genvar d = 0; d < DIMS; d++) begin : g_wire
      localparam int PEER = i ^ (1 << d);
      assign li_v[i][d] = lo_v[PEER][d];
      assign lo_rdy[i][d] = li_rdy[PEER][d];
      assign li_dest[i][d*DIMS +: DIMS] = lo_dest[PEER][d*DIMS +: DIMS];
      assign li_hops[i][d*HW +: HW] = lo_hops[PEER][d*HW +: HW];
      assign li_data[i][d*DW +: DW] = lo_data[PEER][d*DW +: DW];
    end
    hcube_node #(.DIMS(DIMS), .DATA_W(DW), .HOP_W(HW), .NODE_ID(DIMS'(i))) u_hcube_node (
      .clk(clk), .rst_n(rst_n),
      .loc_in_valid(c_ci_v[i]), .loc_in_ready(c_ci_rdy[i]), .loc_in_dest(c_ci_dest[i]),
      .loc_in_hops(HW'(0)), .loc_in_data(c_ci_data[i]),
      .loc_out_valid(c_co_v[i]), .loc_out_ready(1'b1), .loc_out_dest(c_co_dest[i]),
      .loc_out_hops(c_co_hops[i]), .loc_out_data(c_co_data[i]),
      .lnk_in_valid(li_v[i]), .lnk_in_ready(li_rdy[i]), .lnk_in_dest(li_dest[i]),
      .lnk_in_hops(li_hops[i]), .lnk_in_data(li_data[i]),
      .lnk_out_valid(lo_v[i]), .lnk_out_ready(lo_rdy[i]), .lnk_out_dest(lo_dest[i]),
      .lnk_out_hops(lo_hops[i]), .lnk_out_data(lo_data[i]));
  end

  int got [N*N];
  bit net_on = 0;

  // Each delivered message is valid for exactly one negedge (local ready tied high).
  always @(negedge clk) begin
    if (net_on)
      for (int n = 0; n < N; n++)
        if (c_co_v[n]) begin
          int src, dst;
          src = int'(c_co_data[n][7:4]);
          dst = int'(c_co_data[n][3:0]);
          check(dst == n && c_co_data[n][15:8] == 8'h5A, "R8 payload at destination", int'(c_co_data[n]), 16'h5A00 + src*16 + n);
          check(c_co_dest[n] == DIMS'(n), "R2 local delivery dest", int'(c_co_dest[n]), n);
          check(int'(c_co_hops[n]) == $countones(src ^ n), "R4 end-to-end hops", int'(c_co_hops[n]), $countones(src ^ n));
          if (dst == n) got[src*N + n]++;
        end
  end

  // ---------------- scenario tasks ----------------
  task automatic t_reset();
    check(s_co_v == 0 && s_lo_v == '0, "R1 outputs idle in reset", {s_co_v, s_lo_v}, 0);
    check(c_co_v == '0, "R1 cube idle in reset", int'(c_co_v), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(s_co_v == 0 && s_lo_v == '0, "R1 outputs idle after reset", {s_co_v, s_lo_v}, 0);
  endtask

  task automatic t_local();
    @(negedge clk);
    s_ci_v = 1; s_ci_dest = ME; s_ci_hops = 2'd2; s_ci_data = 16'hBEEF;
    #1 check(s_ci_rdy == 1, "R6 lone local input granted", s_ci_rdy, 1);
    @(negedge clk);
    s_ci_v = 0;
    check(s_co_v == 1 && s_lo_v == '0, "R5 local delivery after one edge", {s_co_v, s_lo_v}, 8);
    check(s_co_dest == ME && s_co_hops == 2'd2, "R2 dest and hops unchanged", {s_co_dest, s_co_hops}, {ME, 2'd2});
    check(s_co_data == 16'hBEEF, "R8 local payload", int'(s_co_data), 16'hBEEF);
    @(negedge clk);
    check(s_co_v == 0, "R7 taken output clears", s_co_v, 0);
  endtask

  task automatic t_route();
    int dests [4] = '{4, 1, 2, 7};
    foreach (dests[k]) begin
      int ax;
      ax = low_axis(dests[k] ^ int'(ME));
      @(negedge clk);
      s_ci_v = 1; s_ci_dest = DIMS'(dests[k]); s_ci_hops = 2'd1; s_ci_data = DW'(16'h3000 + dests[k]);
      @(negedge clk);
      s_ci_v = 0;
      check(s_lo_v == DIMS'(1 << ax) && s_co_v == 0, "R3 lowest differing axis", int'(s_lo_v), 1 << ax);
      check(s_lo_hops[ax*HW +: HW] == 2'd2, "R4 hop count incremented", int'(s_lo_hops[ax*HW +: HW]), 2);
      check(s_lo_data[ax*DW +: DW] == DW'(16'h3000 + dests[k]) && s_lo_dest[ax*DIMS +: DIMS] == DIMS'(dests[k]),
            "R8 forwarded payload", int'(s_lo_data[ax*DW +: DW]), 16'h3000 + dests[k]);
    end
    @(negedge clk);
  endtask

  task automatic t_prio();
    @(negedge clk);
    s_li_v = 3'b110;
    s_li_dest = {3'd4, 3'd4, 3'd0};
    s_li_hops = '0;
    s_li_data = {16'hCC02, 16'hCC01, 16'h0000};
    s_ci_v = 1; s_ci_dest = 3'd4; s_ci_hops = 0; s_ci_data = 16'hCC0F;
    #1 check(s_li_rdy == 3'b010 && s_ci_rdy == 0, "R6 link1 beats link2 and local", {s_li_rdy, s_ci_rdy}, 4'b0100);
    @(negedge clk);
    s_li_v[1] = 0;
    check(s_lo_v[0] && s_lo_data[15:0] == 16'hCC01, "R6 first winner data", int'(s_lo_data[15:0]), 16'hCC01);
    #1 check(s_li_rdy == 3'b000 && s_ci_rdy == 0, "R7 full output blocks inputs", {s_li_rdy, s_ci_rdy}, 0);
    @(negedge clk);
    #1 check(s_li_rdy == 3'b100 && s_ci_rdy == 0, "R6 link2 beats local", {s_li_rdy, s_ci_rdy}, 4'b1000);
    @(negedge clk);
    s_li_v[2] = 0;
    check(s_lo_v[0] && s_lo_data[15:0] == 16'hCC02, "R6 second winner data", int'(s_lo_data[15:0]), 16'hCC02);
    @(negedge clk);
    #1 check(s_ci_rdy == 1, "R6 local served last", s_ci_rdy, 1);
    @(negedge clk);
    s_ci_v = 0;
    check(s_lo_v[0] && s_lo_data[15:0] == 16'hCC0F, "R6 third winner data", int'(s_lo_data[15:0]), 16'hCC0F);
    @(negedge clk);
  endtask

  task automatic t_hold();
    @(negedge clk);
    s_lo_rdy = 3'b101;
    s_ci_v = 1; s_ci_dest = 3'd7; s_ci_hops = 0; s_ci_data = 16'hD00D;
    @(negedge clk);
    s_ci_v = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(s_lo_v[1] && s_lo_data[DW +: DW] == 16'hD00D && s_lo_hops[HW +: HW] == 2'd1,
            "R7 stalled output held", int'(s_lo_data[DW +: DW]), 16'hD00D);
    end
    s_ci_v = 1; s_ci_data = 16'hE00E;
    #1 check(s_ci_rdy == 0, "R7 stalled output refuses input", s_ci_rdy, 0);
    @(negedge clk);
    check(s_ci_rdy == 0 && s_lo_data[DW +: DW] == 16'hD00D, "R7 still refused, data kept", s_ci_rdy, 0);
    s_lo_rdy = 3'b111;
    @(negedge clk);
    #1 check(s_ci_rdy == 1 && s_lo_v[1] == 0, "R7 drained output reopens", s_ci_rdy, 1);
    @(negedge clk);
    s_ci_v = 0;
    check(s_lo_v[1] && s_lo_data[DW +: DW] == 16'hE00E, "R8 queued message follows", int'(s_lo_data[DW +: DW]), 16'hE00E);
    @(negedge clk);
  endtask

  task automatic t_network();
    net_on = 1;
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) begin
        @(negedge clk);
        c_ci_v[s] = 1; c_ci_dest[s] = DIMS'(d); c_ci_data[s] = DW'(16'h5A00 + s*16 + d);
        #1;
        while (!c_ci_rdy[s]) begin
          @(negedge clk);
          #1;
        end
        @(negedge clk);
        c_ci_v[s] = 0;
      end
    repeat (30) @(negedge clk);
    for (int p = 0; p < N*N; p++)
      check(got[p] == 1, "R9 pair delivered once", got[p], 1);
    net_on = 0;
  endtask

  initial begin
    for (int n = 0; n < N; n++) begin
      c_ci_dest[n] = '0;
      c_ci_data[n] = '0;
    end
    for (int p = 0; p < N*N; p++) got[p] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_local();
    t_route();
    t_prio();
    t_hold();
    t_network();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule